// File: doc/BRIEF.md
# Output-Stationary Tiled Matrix Multiply Array

This block computes C = W × X for a signed fixed-point weight matrix W and input matrix X on a square grid of processing elements. The output matrix is divided into square tiles, and each processing element keeps one of them in its own set of accumulators. With the default parameters the grid is 4 × 4 elements, the tiles are 4 × 4, operands are signed 16-bit values and accumulators are 32 bits wide. The full output is therefore 16 × 16.

A run begins when `start` is pulsed with a reduction step count. The controller walks the shared dimension one tile step at a time. Each step spans TS cycles, and in each cycle one k index is read. The operand read port returns a whole column slice of W and a whole row slice of X for that k index in the same cycle the index is presented. The W slice for each array row is broadcast across that row, and the X slice for each array column is broadcast down that column. Every element then adds the outer product of its two slices into its output tile.

The first accumulation of a run replaces the stored values instead of adding to them. After the final step, the results leave one 32-bit value per valid/ready beat. `done` then rises and stays high until the next run is started.

Top module: `gemm_os_array`

## Requirements
- R1: After reset, `busy`, `done`, `out_valid` and `rd_en` are all low.
- R2: A `start` accepted while idle latches `steps`. It then asserts `rd_en` for exactly steps×TS consecutive cycles, with `rd_k` counting 0, 1, 2, … one per cycle, and `rd_en` is never high outside those cycles.
- R3: Each result equals the sum over k in 0 … steps×TS−1 of W[row][k]·X[k][col], taken as signed values and reduced modulo 2^AW.
- R4: Within each read, bits [m·DW +: DW] of `w_data` carry W[m][rd_k], and bits [n·DW +: DW] of `x_data` carry X[rd_k][n], for m and n in 0 … ARR·TS−1.
- R5: Results leave as exactly ARR²·TS² beats. Beat b belongs to grid row b/(ARR·TS²), grid column (b/TS²) mod ARR, tile row (b/TS) mod TS and tile column b mod TS, which is output row (grid row)·TS + (tile row) and output column (grid column)·TS + (tile column). `out_last` is high only on the final beat.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. No beat is lost or repeated.
- R7: `busy` falls and `done` rises in the cycle after the last beat is accepted. `done` then holds until the next accepted `start`, which clears it.
- R8: A `start` pulse while `busy` is high has no effect: it changes neither the number of reads nor the results of the run in progress.
- R9: A new run never includes values left from an earlier run, because its first accumulation overwrites the stored tiles.
- R10: A step count of zero issues no reads and drains all-zero results.
- R11: Sums that pass the accumulator range wrap modulo 2^AW, and operands of −2^(DW−1) are handled as signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| steps | input | SW | Number of reduction tile steps for the run |
| busy | output | 1 | High from an accepted start until the last beat is accepted |
| done | output | 1 | High after a completed run, until the next start |
| rd_en | output | 1 | Operand read strobe |
| rd_k | output | SW+log2(TS) | Shared-dimension index being read |
| w_data | input | ARR·TS·DW | Weight column slice for `rd_k`, same cycle |
| x_data | input | ARR·TS·DW | Input row slice for `rd_k`, same cycle |
| out_valid | output | 1 | Result beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | AW | Signed result value |
| out_last | output | 1 | Final beat of the run |

## Verification
The hardest situation to reach from the ports is a run whose first accumulation has to overwrite tiles that still hold a large earlier result. A fresh block starts from zeros and hides a missing clear. The stimulus therefore runs several blocks back to back with different operand contents and step counts, including a zero-step run that follows a populated one. A second hard case is a `start` that arrives while reads are still in flight. The bench injects it partway through the read phase with a different step count, then confirms that the read count and the drained sums match the original request.

// File: rtl/gemm_os_pkg.sv
package gemm_os_pkg;

  // Controller phases.
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_ZERO,
    ST_DRAIN
  } os_state_e;

endpackage

// File: rtl/gemm_os_ctrl.sv
module gemm_os_ctrl
  import gemm_os_pkg::*;
#(
  parameter int ARR = 4,
  parameter int TS  = 4,
  parameter int SW  = 8,
  localparam int KW   = $clog2(TS),
  localparam int KAW  = SW + KW,
  localparam int NOUT = ARR * ARR * TS * TS,
  localparam int OIW  = $clog2(NOUT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [SW-1:0]  steps,
  input  logic           out_ready,
  output logic           busy,
  output logic           done,
  output logic           rd_en,
  output logic [KAW-1:0] rd_k,
  output logic           acc_en,
  output logic           acc_clr,
  output logic           out_valid,
  output logic           out_last,
  output logic [OIW-1:0] out_idx
);

  os_state_e      state_q;
  logic [SW-1:0]  steps_q;
  logic [SW-1:0]  step_q;
  logic [KW-1:0]  kk_q;
  logic [OIW-1:0] idx_q;
  logic           done_q;

  logic last_k, last_step, last_beat, first_pos;

  assign last_k    = (kk_q == KW'(TS - 1));
  assign last_step = (step_q == steps_q - SW'(1));
  assign last_beat = (idx_q == OIW'(NOUT - 1));
  assign first_pos = (step_q == '0) && (kk_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      steps_q <= '0;
      step_q  <= '0;
      kk_q    <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            steps_q <= steps;
            step_q  <= '0;
            kk_q    <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
            state_q <= (steps == '0) ? ST_ZERO : ST_RUN;
          end
        end
        ST_RUN: begin
          if (last_k) begin
            kk_q   <= '0;
            step_q <= step_q + SW'(1);
            if (last_step) state_q <= ST_DRAIN;
          end else begin
            kk_q <= kk_q + KW'(1);
          end
        end
        ST_ZERO: state_q <= ST_DRAIN;
        ST_DRAIN: begin
          if (out_ready) begin
            if (last_beat) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + OIW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign rd_en     = (state_q == ST_RUN);
  assign rd_k      = {step_q, kk_q};
  assign acc_en    = (state_q == ST_RUN);
  assign acc_clr   = ((state_q == ST_RUN) && first_pos) || (state_q == ST_ZERO);
  assign out_valid = (state_q == ST_DRAIN);
  assign out_last  = out_valid && last_beat;
  assign out_idx   = idx_q;

endmodule

// File: rtl/gemm_os_pe.sv
module gemm_os_pe #(
  parameter int TS = 4,
  parameter int DW = 16,
  parameter int AW = 32,
  localparam int TT = TS * TS,
  localparam int TW = $clog2(TT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [TS*DW-1:0] w_vec,
  input  logic [TS*DW-1:0] x_vec,
  input  logic [TW-1:0]    sel,
  output logic [AW-1:0]    rd_val
);

  // Signed multiply-accumulate, result reduced to the accumulator width.
  function automatic logic [AW-1:0] mac_step(input logic [AW-1:0] base,
                                             input logic signed [DW-1:0] a,
                                             input logic signed [DW-1:0] b);
    logic signed [AW-1:0] ea, eb;
    ea = AW'(a);
    eb = AW'(b);
    return base + AW'(ea * eb);
  endfunction

  logic [AW-1:0] acc [TT];

  for (genvar i = 0; i < TS; i++) begin : g_row
    for (genvar j = 0; j < TS; j++) begin : g_col
      logic signed [DW-1:0] a_el, b_el;
      assign a_el = w_vec[i*DW +: DW];
      assign b_el = x_vec[j*DW +: DW];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc[i*TS+j] <= '0;
        end else if (clr) begin
          acc[i*TS+j] <= en ? mac_step('0, a_el, b_el) : '0;
        end else if (en) begin
          acc[i*TS+j] <= mac_step(acc[i*TS+j], a_el, b_el);
        end
      end
    end
  end

  assign rd_val = acc[sel];

endmodule

// File: rtl/gemm_os_array.sv
module gemm_os_array #(
  parameter int ARR = 4,
  parameter int TS  = 4,
  parameter int DW  = 16,
  parameter int AW  = 32,
  parameter int SW  = 8,
  localparam int MDIM = ARR * TS,
  localparam int KAW  = SW + $clog2(TS),
  localparam int TT   = TS * TS,
  localparam int TW   = $clog2(TT),
  localparam int NOUT = ARR * ARR * TT,
  localparam int OIW  = $clog2(NOUT),
  localparam int PSW  = OIW - TW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SW-1:0]      steps,
  output logic               busy,
  output logic               done,
  output logic               rd_en,
  output logic [KAW-1:0]     rd_k,
  input  logic [MDIM*DW-1:0] w_data,
  input  logic [MDIM*DW-1:0] x_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [AW-1:0]      out_data,
  output logic               out_last
);

  logic           acc_en;
  logic           acc_clr;
  logic [OIW-1:0] out_idx;
  logic [PSW-1:0] pe_sel;
  logic [TW-1:0]  el_sel;
  logic [AW-1:0]  pe_vals [ARR*ARR];

  gemm_os_ctrl #(.ARR(ARR), .TS(TS), .SW(SW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .steps    (steps),
    .out_ready(out_ready),
    .busy     (busy),
    .done     (done),
    .rd_en    (rd_en),
    .rd_k     (rd_k),
    .acc_en   (acc_en),
    .acc_clr  (acc_clr),
    .out_valid(out_valid),
    .out_last (out_last),
    .out_idx  (out_idx)
  );

  // Row r of the grid shares a weight slice; column c shares an input slice.
  for (genvar r = 0; r < ARR; r++) begin : g_arow
    for (genvar c = 0; c < ARR; c++) begin : g_acol
      gemm_os_pe #(.TS(TS), .DW(DW), .AW(AW)) u_pe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (acc_en),
        .clr   (acc_clr),
        .w_vec (w_data[r*TS*DW +: TS*DW]),
        .x_vec (x_data[c*TS*DW +: TS*DW]),
        .sel   (el_sel),
        .rd_val(pe_vals[r*ARR+c])
      );
    end
  end

  // Drain index: upper bits pick the element (row-major), lower bits the tile entry.
  assign pe_sel   = out_idx[OIW-1:TW];
  assign el_sel   = out_idx[TW-1:0];
  assign out_data = pe_vals[pe_sel];

endmodule

// File: rtl/gemm_os_chk.sv
module gemm_os_chk #(
  parameter int SW  = 8,
  parameter int KAW = 10,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [SW-1:0]  steps,
  input logic           busy,
  input logic           done,
  input logic           rd_en,
  input logic [KAW-1:0] rd_k,
  input logic           acc_en,
  input logic           acc_clr,
  input logic           out_valid,
  input logic           out_ready,
  input logic [AW-1:0]  out_data,
  input logic           out_last
);

  p_rd_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy && !out_valid);

  p_k_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_k == $past(rd_k) + KAW'(1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> done && !busy);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  p_busy_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(out_valid && out_ready && out_last) |=> busy);

  p_first_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && rd_k == '0 |-> acc_clr);

  p_zero_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && steps == '0 |=> acc_clr && !rd_en);

endmodule

bind gemm_os_array gemm_os_chk #(.SW(SW), .KAW(KAW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .steps    (steps),
  .busy     (busy),
  .done     (done),
  .rd_en    (rd_en),
  .rd_k     (rd_k),
  .acc_en   (acc_en),
  .acc_clr  (acc_clr),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last)
);

// File: tb/sim_gemm_os_array.sv
module sim_gemm_os_array;
  localparam int CLK_PERIOD = 10;
  localparam int ARR = 4, TS = 4, DW = 16, AW = 32, SW = 8;
  localparam int MD = ARR * TS, TT = TS * TS, NOUT = ARR * ARR * TT;
  localparam int KAW = SW + $clog2(TS);
  localparam int KM = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [SW-1:0] steps = '0;
  logic busy, done, rd_en, out_valid, out_last;
  logic [KAW-1:0] rd_k;
  logic [MD*DW-1:0] w_data, x_data;
  logic [AW-1:0] out_data;

  logic signed [DW-1:0] wm [MD][KM];
  logic signed [DW-1:0] xm [KM][MD];

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gemm_os_array #(.ARR(ARR), .TS(TS), .DW(DW), .AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .steps(steps), .busy(busy),
    .done(done), .rd_en(rd_en), .rd_k(rd_k), .w_data(w_data), .x_data(x_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last));

  // Operand port model (R4 layout), data returned in the same cycle.
  always_comb begin
    for (int m = 0; m < MD; m++) begin
      w_data[m*DW +: DW] = wm[m][rd_k[5:0]];
      x_data[m*DW +: DW] = xm[rd_k[5:0]][m];
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode 0: random, 1: scaled identity/ramp, 2: extreme signed values
  task automatic fill(input int mode);
    for (int m = 0; m < MD; m++)
      for (int k = 0; k < KM; k++) begin
        case (mode)
          0: begin wm[m][k] = 16'($urandom); xm[k][m] = 16'($urandom); end
          1: begin wm[m][k] = (m == k % MD) ? 16'sd3 : 16'sd0; xm[k][m] = 16'(k * 7 - m); end
          default: begin
            wm[m][k] = ($urandom % 2) ? 16'sh8000 : 16'sh7fff;
            xm[k][m] = ($urandom % 2) ? 16'sh8000 : 16'sh7fff;
          end
        endcase
      end
  endtask

  // Reference result for drain beat n (R3, R5 ordering).
  function automatic logic [31:0] exp_val(input int n, input int nsteps);
    int pr, pc, ti, tj, row, col, s;
    pr = n / (ARR * TT); pc = (n / TT) % ARR; ti = (n / TS) % TS; tj = n % TS;
    row = pr * TS + ti; col = pc * TS + tj; s = 0;
    for (int k = 0; k < nsteps * TS; k++) s = s + int'(wm[row][k]) * int'(xm[k][col]);
    return s;
  endfunction

  // rmode 0: always ready, 1: every third cycle, 2: random. poke: start while busy.
  task automatic run_block(input int nsteps, input int rmode, input bit poke,
                           input string tag);
    int reads, beats, cyc, held_v;
    logic [31:0] held;
    bit r;
    @(posedge clk); #1;
    steps = SW'(nsteps); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    reads = 0; cyc = 0;
    @(negedge clk);
    while (!out_valid && cyc < 5000) begin
      if (rd_en) begin
        chk(rd_k == KAW'(reads), {tag, " R2 rd_k order"}, 32'(rd_k), reads);
        reads++;
        if (poke && reads == 2) begin start = 1'b1; steps = SW'(nsteps + 3); end
        else start = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(reads == nsteps * TS, {tag, " R2/R8/R10 read count"}, reads, nsteps * TS);
    beats = 0; held_v = 0; held = '0;
    while (beats < NOUT && cyc < 20000) begin
      r = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 == 0) : 1'($urandom);
      out_ready = r;
      if (held_v != 0)
        chk(out_valid && out_data == held, {tag, " R6 held beat"}, out_data, held);
      if (out_valid) begin
        if (r) begin
          chk(out_data == exp_val(beats, nsteps), {tag, " R3/R9/R11 result"},
              out_data, exp_val(beats, nsteps));
          chk(out_last == (beats == NOUT - 1), {tag, " R5 last flag"}, 32'(out_last),
              32'(beats == NOUT - 1));
          beats++; held_v = 0;
        end else begin
          held_v = 1; held = out_data;
        end
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(beats == NOUT, {tag, " R5 beat count"}, beats, NOUT);
    chk(done && !busy && !out_valid, {tag, " R7 done after drain"},
        {29'd0, done, busy, out_valid}, 32'b100);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !out_valid && !rd_en, "R1 reset state",
        {28'd0, busy, done, out_valid, rd_en}, 0);
  endtask

  task automatic t_basic();
    fill(1);
    run_block(1, 0, 1'b0, "basic");
    run_block(4, 0, 1'b0, "ramp4");
  endtask

  task automatic t_backpressure();
    fill(0);
    run_block(4, 2, 1'b0, "random_bp");
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R7 done holds while idle", 32'(done), 1);
  endtask

  task automatic t_reclear();
    fill(0);
    run_block(2, 1, 1'b0, "reclear R9");
  endtask

  task automatic t_busy_start();
    fill(0);
    run_block(2, 0, 1'b1, "busy_start R8");
  endtask

  task automatic t_zero();
    run_block(0, 0, 1'b0, "zero R10");
  endtask

  task automatic t_extreme();
    fill(2);
    run_block(3, 1, 1'b0, "extreme R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_reclear();
    t_busy_start();
    t_zero();
    t_extreme();
    t_reclear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule